// File: doc/BRIEF.md
# Hamming-Distance Threshold Authenticator

This block decides whether a freshly recovered device response is close enough to the stored reference to count as the same device. Both responses arrive as two parallel word streams that share one valid strobe. Each accepted beat adds the number of bit positions in which the two words differ to a running distance. When the frame closes, the block compares that distance with a programmable bit-count threshold and reports accept or reject, together with the raw distance.

Software chooses the error-rate limit as a whole number of bits: the fraction times the response length. The default of 61 bits is about 3 % of 2048. The 12-bit threshold covers the whole useful span, from roughly 12 bits (0.6 %) to about 888 bits (43.4 %), and beyond. A start pulse opens each frame. A frame that closes at the wrong word count is flagged as a length error and always rejected.

Top module: `resp_match_judge`

## Requirements
- R1: After a well-formed frame, `distance` equals the number of bit positions in which `ref_word` and `cand_word` differed, summed over all RESP_BITS/WORD_W beats of the frame (64 beats of 32 bits by default).
- R2: For a well-formed frame, `accept` is 1 when `distance` is less than or equal to the threshold register, and 0 when it is greater. The comparison includes equality.
- R3: The threshold register is 12 bits wide and resets to 61. It loads `cfg_thresh` on any cycle with `cfg_we` high, and any value from 0 to 4095 can be stored.
- R4: `done` is high for exactly one cycle, the cycle after the beat that closes the frame. `accept`, `distance` and `len_err` take their new values in that same cycle and hold them until the next `start`.
- R5: A `start` pulse clears `done`, `accept`, `distance` and `len_err` in the next cycle and opens a new frame at beat 0. A beat presented in the same cycle as `start` is ignored.
- R6: If `in_last` is high on a beat before the final beat index, the frame closes there with `len_err`=1 and `accept`=0. `distance` holds the count over the beats received.
- R7: If the final beat index (63 by default) arrives without `in_last`, the frame closes there with `len_err`=1 and `accept`=0.
- R8: Beats are ignored before the first `start` and after a frame has closed. Ignored beats produce no `done` pulse and leave `distance` unchanged.
- R9: After reset, `done`, `accept`, `distance` and `len_err` are 0.
- R10: Cycles with `in_valid` low neither advance the beat index nor change the running count, so idle gaps inside a frame give the same result as an unbroken frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Threshold write enable |
| cfg_thresh | input | 12 | New threshold in bits |
| start | input | 1 | Opens a new frame and clears the results |
| in_valid | input | 1 | A beat is present on both word streams |
| in_last | input | 1 | Marks the closing beat of the frame |
| ref_word | input | 32 | Reference response word |
| cand_word | input | 32 | Candidate response word |
| done | output | 1 | One-cycle strobe: results are fresh |
| accept | output | 1 | Decision: distance is within the threshold |
| distance | output | 12 | Hamming distance of the frame |
| len_err | output | 1 | Frame closed at the wrong beat count |

## Verification
Every result of this block is due in the cycle after the closing beat. A `done` strobe, a new `distance`, `accept` or `len_err`, and the cleared state after `start` all show up one register stage after the edge that samples the causing input. The bench drives inputs on falling edges. It reads each result on the falling edge that follows the rising edge which captured the closing beat or the start pulse. It then reads once more one cycle later to confirm that `done` has dropped and the results are held. The checks for ignored beats read `done` and `distance` on the falling edge after the last ignored beat.

// File: rtl/rmj_pkg.sv
package rmj_pkg;
   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_RUN  = 1'b1
   } frame_state_e;

   function automatic int safe_clog2(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction
endpackage

// File: rtl/rmj_popcount.sv
module rmj_popcount #(
   parameter int W        = 32,
   parameter bit USE_TREE = 1'b1,
   localparam int PW      = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] ones
);
   if (W < 2) begin : g_bad_w
      $error("rmj_popcount: W must be at least 2");
   end

   if (USE_TREE) begin : g_tree
      if ((W & (W - 1)) != 0) begin : g_bad_pow
         $error("rmj_popcount: tree variant needs a power-of-two W");
      end
      // heap-indexed adder tree: leaves at W-1 .. 2W-2, root at 0
      logic [PW-1:0] node [2*W-1];
      for (genvar i = 0; i < W; i++) begin : g_leaf
         assign node[W-1+i] = {{(PW-1){1'b0}}, vec[i]};
      end
      for (genvar k = 0; k < W - 1; k++) begin : g_sum
         assign node[k] = node[2*k+1] + node[2*k+2];
      end
      assign ones = node[0];
   end else begin : g_linear
      always_comb begin
         ones = '0;
         for (int i = 0; i < W; i++) begin
            ones = ones + {{(PW-1){1'b0}}, vec[i]};
         end
      end
   end
endmodule

// File: rtl/rmj_frame_ctrl.sv
module rmj_frame_ctrl
   import rmj_pkg::*;
#(
   parameter int WORDS = 64,
   localparam int WCW  = safe_clog2(WORDS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   input  logic in_last,
   output logic beat_take,
   output logic frame_end,
   output logic len_bad
);
   frame_state_e   st_q;
   logic [WCW-1:0] idx_q;
   logic           at_final;

   assign at_final  = (idx_q == WCW'(WORDS - 1));
   assign beat_take = (st_q == FR_RUN) && in_valid && !start;
   assign frame_end = beat_take && (in_last || at_final);
   assign len_bad   = frame_end && (in_last != at_final);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= FR_IDLE;
         idx_q <= '0;
      end else if (start) begin
         st_q  <= FR_RUN;
         idx_q <= '0;
      end else if (frame_end) begin
         st_q  <= FR_IDLE;
         idx_q <= '0;
      end else if (beat_take) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   // R7: beat index never runs past the final beat
   a_r7_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= WCW'(WORDS - 1));
   // R5: start opens a frame at beat 0
   a_r5_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (st_q == FR_RUN) && (idx_q == '0));
   // R8: after a frame closes, no further beat is taken until start
   a_r8_closed_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && !start |=> !beat_take || start);
endmodule

// File: rtl/rmj_dist_acc.sv
module rmj_dist_acc #(
   parameter int W     = 32,
   parameter int CNT_W = 12,
   localparam int PW   = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [PW-1:0]    ones,
   output logic [CNT_W-1:0] total
);
   logic [CNT_W-1:0] acc_q;

   if (CNT_W < PW) begin : g_bad_cnt
      $error("rmj_dist_acc: counter narrower than one word count");
   end

   // running sum including the beat being presented this cycle
   assign total = acc_q + (add ? CNT_W'(ones) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (clr)  acc_q <= '0;
      else if (add)  acc_q <= total;
   end

   // R10: idle cycles leave the running count untouched
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !add |=> $stable(acc_q));
endmodule

// File: rtl/rmj_decide.sv
module rmj_decide #(
   parameter int                RESP_BITS = 2048,
   parameter int                CNT_W     = 12,
   parameter logic [CNT_W-1:0]  THR_RESET = 61
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_thresh,
   input  logic             frame_end,
   input  logic             len_bad,
   input  logic [CNT_W-1:0] total,
   output logic             done,
   output logic             accept,
   output logic [CNT_W-1:0] distance,
   output logic             len_err
);
   logic [CNT_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       thr_q <= THR_RESET;
      else if (cfg_we)  thr_q <= cfg_thresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         accept   <= 1'b0;
         distance <= '0;
         len_err  <= 1'b0;
      end else if (start) begin
         done     <= 1'b0;
         accept   <= 1'b0;
         distance <= '0;
         len_err  <= 1'b0;
      end else if (frame_end) begin
         done     <= 1'b1;
         accept   <= !len_bad && (total <= thr_q);
         distance <= total;
         len_err  <= len_bad;
      end else begin
         done     <= 1'b0;
      end
   end

   // R4: done is a single-cycle strobe
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: results hold between frame end and the next start
   a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start && !frame_end |=> $stable(distance) && $stable(accept) && $stable(len_err));
   // R6: a length error is never accepted
   a_r6_len_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> !accept);
   // R5: start clears the results
   a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done && !accept && !len_err && (distance == '0));
   // R1: distance never exceeds the response length
   a_r1_dist_bound: assert property (@(posedge clk) disable iff (!rst_n)
      distance <= CNT_W'(RESP_BITS));
endmodule

// File: rtl/resp_match_judge.sv
module resp_match_judge #(
   parameter int  RESP_BITS       = 2048,
   parameter int  WORD_W          = 32,
   parameter int  THR_RESET       = 61,
   parameter bit  POP_TREE        = 1'b1,
   localparam int CNT_W           = $clog2(RESP_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CNT_W-1:0]  cfg_thresh,
   input  logic              start,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic [WORD_W-1:0] ref_word,
   input  logic [WORD_W-1:0] cand_word,
   output logic              done,
   output logic              accept,
   output logic [CNT_W-1:0]  distance,
   output logic              len_err
);
   localparam int WORDS = RESP_BITS / WORD_W;
   localparam int PW    = $clog2(WORD_W + 1);

   if (RESP_BITS % WORD_W != 0) begin : g_bad_len
      $error("resp_match_judge: RESP_BITS must be a multiple of WORD_W");
   end
   if (THR_RESET >= (1 << CNT_W)) begin : g_bad_thr
      $error("resp_match_judge: THR_RESET does not fit the threshold field");
   end

   logic             beat_take;
   logic             frame_end;
   logic             len_bad;
   logic [PW-1:0]    ones;
   logic [CNT_W-1:0] total;

   rmj_frame_ctrl #(.WORDS(WORDS)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .beat_take (beat_take),
      .frame_end (frame_end),
      .len_bad   (len_bad)
   );

   rmj_popcount #(.W(WORD_W), .USE_TREE(POP_TREE)) u_pop (
      .vec  (ref_word ^ cand_word),
      .ones (ones)
   );

   rmj_dist_acc #(.W(WORD_W), .CNT_W(CNT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .add   (beat_take),
      .ones  (ones),
      .total (total)
   );

   rmj_decide #(
      .RESP_BITS (RESP_BITS),
      .CNT_W     (CNT_W),
      .THR_RESET (CNT_W'(THR_RESET))
   ) u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_we     (cfg_we),
      .cfg_thresh (cfg_thresh),
      .frame_end  (frame_end),
      .len_bad    (len_bad),
      .total      (total),
      .done       (done),
      .accept     (accept),
      .distance   (distance),
      .len_err    (len_err)
   );

   // R8: no result strobe without an open frame having taken a beat
   a_r8_done_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(beat_take));
endmodule

// File: tb/test_resp_match_judge.sv
module test_resp_match_judge;
   localparam int RB = 2048;
   localparam int WW = 32;
   localparam int NW = RB / WW;

   typedef struct packed {
      logic [11:0] thr;
      logic [11:0] k;
      logic        acc;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{12'd61,   12'd0,    1'b1},
      '{12'd61,   12'd61,   1'b1},
      '{12'd61,   12'd62,   1'b0},
      '{12'd12,   12'd12,   1'b1},
      '{12'd12,   12'd13,   1'b0},
      '{12'd888,  12'd888,  1'b1},
      '{12'd888,  12'd889,  1'b0},
      '{12'd0,    12'd0,    1'b1},
      '{12'd0,    12'd1,    1'b0},
      '{12'd4095, 12'd2048, 1'b1},
      '{12'd61,   12'd2048, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [11:0]   cfg_thresh = '0;
   logic          start = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_last = 1'b0;
   logic [WW-1:0] ref_word = '0;
   logic [WW-1:0] cand_word = '0;
   logic          done;
   logic          accept;
   logic [11:0]   distance;
   logic          len_err;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   resp_match_judge i_resp_match_judge (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
      .start(start), .in_valid(in_valid), .in_last(in_last),
      .ref_word(ref_word), .cand_word(cand_word),
      .done(done), .accept(accept), .distance(distance), .len_err(len_err)
   );

   function automatic logic [WW-1:0] ref_of(input int w);
      return 32'hA5C3_0F96 ^ (32'(w) * 32'h9E37_79B9);
   endfunction

   // bit b of the response is flipped when its scrambled position is below k
   function automatic logic [WW-1:0] flip_of(input int w, input int k);
      logic [WW-1:0] m;
      m = '0;
      for (int j = 0; j < WW; j++) begin
         int b;
         b = w * WW + j;
         m[j] = ((b * 37) % RB) < k;
      end
      return m;
   endfunction

   function automatic int flips_upto(input int k, input int nbits);
      int c;
      c = 0;
      for (int b = 0; b < nbits; b++) if (((b * 37) % RB) < k) c++;
      return c;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_thr(input int v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_thresh = 12'(v);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // drives nbeats beats; in_last on beat lastidx (-1: never); optional idle gaps
   task automatic send_frame(input int k, input int nbeats, input int lastidx, input bit gaps);
      for (int i = 0; i < nbeats; i++) begin
         if (gaps && (i % 3 == 1)) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_last   = 1'b0;
            cand_word = ~cand_word;
         end
         @(negedge clk);
         in_valid  = 1'b1;
         in_last   = (i == lastidx);
         ref_word  = ref_of(i);
         cand_word = ref_of(i) ^ flip_of(i, k);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R4 watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "done", done, 0);
      chk("R9", "accept", accept, 0);
      chk("R9", "distance", distance, 0);
      chk("R9", "len_err", len_err, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: beats before any start are ignored
      send_frame(7, NW, NW - 1, 1'b0);
      chk("R8", "done before start", done, 0);
      chk("R8", "distance before start", distance, 0);

      // R3: default threshold is 61 (inclusive)
      pulse_start();
      chk("R5", "distance after start", distance, 0);
      send_frame(61, NW, NW - 1, 1'b0);
      chk("R3", "default thr accept at 61", accept, 1);
      pulse_start();
      send_frame(62, NW, NW - 1, 1'b0);
      chk("R3", "default thr reject at 62", accept, 0);

      // R1 R2 R4 R10: vector table
      for (int v = 0; v < NV; v++) begin
         set_thr(int'(VEC[v].thr));
         pulse_start();
         chk("R5", "done cleared by start", done, 0);
         send_frame(int'(VEC[v].k), NW, NW - 1, (v % 3) == 2);
         chk("R4", "done strobe", done, 1);
         chk("R1", "distance", distance, int'(VEC[v].k));
         chk("R2", "accept", accept, int'(VEC[v].acc));
         chk("R2", "len_err clear", len_err, 0);
         @(negedge clk);
         chk("R4", "done drops", done, 0);
         chk("R4", "distance held", distance, int'(VEC[v].k));
         chk("R4", "accept held", accept, int'(VEC[v].acc));
      end

      // R6: early closing marker
      set_thr(4095);
      pulse_start();
      send_frame(500, 11, 10, 1'b0);
      chk("R6", "done", done, 1);
      chk("R6", "len_err", len_err, 1);
      chk("R6", "accept", accept, 0);
      chk("R6", "partial distance", distance, flips_upto(500, 11 * WW));

      // R7: final beat without closing marker
      set_thr(61);
      pulse_start();
      send_frame(5, NW, -1, 1'b0);
      chk("R7", "done", done, 1);
      chk("R7", "len_err", len_err, 1);
      chk("R7", "accept", accept, 0);
      chk("R7", "distance", distance, 5);

      // R8: beats after frame close are ignored
      pulse_start();
      send_frame(10, NW, NW - 1, 1'b0);
      chk("R8", "first result", distance, 10);
      send_frame(900, 5, 4, 1'b0);
      chk("R8", "no done after close", done, 0);
      chk("R8", "distance unchanged", distance, 10);
      chk("R8", "accept unchanged", accept, 1);

      // R5: a beat in the start cycle is ignored
      @(negedge clk);
      start     = 1'b1;
      in_valid  = 1'b1;
      ref_word  = '0;
      cand_word = '1;
      @(negedge clk);
      start    = 1'b0;
      in_valid = 1'b0;
      chk("R5", "cleared with beat present", distance, 0);
      send_frame(3, NW, NW - 1, 1'b0);
      chk("R5", "start-cycle beat ignored", distance, 3);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule